// File: doc/BRIEF.md
# Write Completion Status Poller

This block runs on the host side of a parallel flash. It waits for a program or erase inside the flash to finish. Once the command sequence has been written (after the fourth write cycle for a program, the sixth for an erase), the host pulses a start input. With that pulse it gives the word address, the data that was written, whether the operation is an erase, and which status method to use. The poller then reads the same address over and over through a simple request/acknowledge read port. It decides completion from the status bits of each returned word.

There are two status methods. The flag method watches bit 7. During a program, bit 7 returns the inverse of the bit being written. During an erase, bit 7 returns 0. The toggle method watches bit 6, which flips on every read while the operation runs and holds still once it ends. A read can land at the very moment the flash finishes, so the rest of the word may not be valid yet. For that reason the poller never accepts the first completion sign alone. It waits a configurable settle gap, reads the word twice more, and requires both reads to match the final value in full. The result comes back as a one-cycle done or error pulse. The error carries a flag that tells a timeout apart from a data mismatch.

Top module: `wr_status_poller`

## Requirements
- R1: While reset is active and after its release, rd_req_o, busy_o, done_o and err_o are low until a start is accepted.
- R2: A start_i seen while idle latches the inputs. From the next cycle, busy_o and rd_req_o are high and rd_addr_o equals the latched address, which holds until the operation ends.
- R3: A start_i seen while busy_o is high is ignored. Address, timing and outcome of the running operation do not change.
- R4: In flag mode (use_toggle_i=0) for a program (op_erase_i=0), a poll read shows completion when its bit 7 equals bit 7 of exp_data_i.
- R5: In flag mode for an erase (op_erase_i=1), a poll read shows completion when its bit 7 is 1.
- R6: In toggle mode (use_toggle_i=1), a poll read shows completion when its bit 6 equals bit 6 of the previous poll read. The first poll read of an operation never shows completion.
- R7: After the completion sign, exactly two confirm reads follow. Each is preceded by SETTLE cycles with rd_req_o low, and every read occupies rd_req_o until the cycle in which rd_ack_i is high.
- R8: A confirm read is valid when the whole word equals exp_data_i (program) or all ones (erase). Two valid confirm reads give done_o. The first invalid one ends the operation at once with err_o and err_timeout_o=0, even if the completion read itself carried invalid low or high bits.
- R9: When max_polls_i poll reads have shown no completion, err_o pulses with err_timeout_o=1. A value of 0 acts as 1. A completion on the last allowed poll read still proceeds to confirmation.
- R10: done_o and err_o are single-cycle pulses, never high together, and each follows directly after a read acknowledge. busy_o is low in the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (taken only while idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| use_toggle_i | input | 1 | 1 = bit 6 toggle method, 0 = bit 7 flag method |
| addr_i | input | AW | Word address to poll |
| exp_data_i | input | DW | Data written by the program |
| max_polls_i | input | CW | Poll-read budget before timeout |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DW | Read response word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| err_timeout_o | output | 1 | With err_o: 1 timeout, 0 mismatch |

## Verification
The bench builds the poller with SETTLE=3 and an 8-bit poll budget. With a settle gap of more than one cycle, an off-by-one in the gap counter changes when the outcome pulse arrives. The bench predicts that arrival cycle exactly for every case. The narrow budget keeps timeout cases short, including the zero budget and a completion that lands on the last allowed poll. A bench flash model returns words whose other bits are invalid for a chosen number of reads after the status bit resolves. The same model can corrupt any chosen read, which reaches both the first and the second confirm read.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  localparam int FLAG_BIT = 7;
  localparam int TGL_BIT  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_GAP,
    ST_CONF
  } wsp_state_e;
endpackage

// File: rtl/wsp_judge.sv
module wsp_judge
  import wsp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd_data_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic          erase_i,
  input  logic          toggle_i,
  input  logic          prev_tgl_i,
  input  logic          prev_ok_i,
  output logic          hit_o,
  output logic          word_ok_o
);
  logic [DW-1:0] final_w;

  always_comb begin
    final_w   = erase_i ? '1 : exp_data_i;
    word_ok_o = (rd_data_i == final_w);
    if (toggle_i) hit_o = prev_ok_i && (rd_data_i[TGL_BIT] == prev_tgl_i);
    else          hit_o = (rd_data_i[FLAG_BIT] == final_w[FLAG_BIT]);
  end
endmodule

// File: rtl/wsp_cnt.sv
module wsp_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end

  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> (q_o != '1));
endmodule

// File: rtl/wr_status_poller.sv
module wr_status_poller
  import wsp_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int SETTLE = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          use_toggle_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          err_timeout_o
);
  localparam int SW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
  localparam wsp_state_e AFTER_HIT = (SETTLE == 0) ? ST_CONF : ST_GAP;

  wsp_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [CW-1:0] limit_q;
  logic          erase_q, tgl_q, prev_tgl_q, prev_ok_q, conf_idx_q;
  logic          done_q, err_q, err_to_q;

  logic          fire, hit, word_ok;
  logic [CW-1:0] poll_cnt;
  logic [SW-1:0] gap_cnt;
  logic [CW:0]   poll_next;
  logic          start_ok;

  assign rd_req_o      = (state_q == ST_POLL) || (state_q == ST_CONF);
  assign rd_addr_o     = addr_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_timeout_o = err_to_q;
  assign fire          = rd_req_o && rd_ack_i;
  assign start_ok      = (state_q == ST_IDLE) && start_i;
  assign poll_next     = {1'b0, poll_cnt} + 1'b1;

  wsp_judge #(.DW(DW)) u_judge (
    .rd_data_i  (rd_data_i),
    .exp_data_i (exp_q),
    .erase_i    (erase_q),
    .toggle_i   (tgl_q),
    .prev_tgl_i (prev_tgl_q),
    .prev_ok_i  (prev_ok_q),
    .hit_o      (hit),
    .word_ok_o  (word_ok)
  );

  wsp_cnt #(.W(CW)) u_poll_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .inc_i  ((state_q == ST_POLL) && fire && !hit),
    .q_o    (poll_cnt)
  );

  wsp_cnt #(.W(SW)) u_gap_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_GAP),
    .inc_i  (state_q == ST_GAP),
    .q_o    (gap_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      exp_q      <= '0;
      limit_q    <= '0;
      erase_q    <= 1'b0;
      tgl_q      <= 1'b0;
      prev_tgl_q <= 1'b0;
      prev_ok_q  <= 1'b0;
      conf_idx_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_to_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q    <= addr_i;
            exp_q     <= exp_data_i;
            erase_q   <= op_erase_i;
            tgl_q     <= use_toggle_i;
            limit_q   <= (max_polls_i == '0) ? CW'(1) : max_polls_i;
            prev_ok_q <= 1'b0;
            err_to_q  <= 1'b0;
            state_q   <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (fire) begin
            prev_tgl_q <= rd_data_i[TGL_BIT];
            prev_ok_q  <= 1'b1;
            if (hit) begin
              conf_idx_q <= 1'b0;
              state_q    <= AFTER_HIT;
            end else if (poll_next >= {1'b0, limit_q}) begin
              err_q    <= 1'b1;
              err_to_q <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == SW'(SETTLE - 1)) state_q <= ST_CONF;
        end
        ST_CONF: begin
          if (fire) begin
            if (!word_ok) begin
              err_q    <= 1'b1;
              err_to_q <= 1'b0;
              state_q  <= ST_IDLE;
            end else if (conf_idx_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              conf_idx_q <= 1'b1;
              state_q    <= AFTER_HIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r10_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> ($past(rd_ack_i) && !busy_o));
  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
  a_r9_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL) |-> (poll_cnt < limit_q));
endmodule

// File: tb/sim_wr_status_poller.sv
`timescale 1ns/1ps
module sim_wr_status_poller;
  localparam int AW = 20, DW = 16, CW = 8, S = 3;

  logic clk = 0, rst_n = 0;
  logic start = 0, erase = 0, tgl = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] expd = '0;
  logic [CW-1:0] maxp = '0;
  logic rd_req, rd_ack = 0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic busy, done, err, err_to;

  int checks = 0, bad = 0;
  bit finished = 0;

  // flash model state
  int m_busy = 0, m_partial = 0, m_reads = 0, m_corrupt = -1;
  logic [DW-1:0] m_final = '0;
  logic m_erase = 0, m_tgl = 0;

  always #2.5 clk = ~clk;

  wr_status_poller #(.AW(AW), .DW(DW), .CW(CW), .SETTLE(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_erase_i(erase),
    .use_toggle_i(tgl), .addr_i(addr), .exp_data_i(expd), .max_polls_i(maxp),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err), .err_timeout_o(err_to));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_word();
    logic [DW-1:0] w;
    m_reads++;
    if (m_busy > 0) begin
      m_busy--;
      w = 16'hA500 | DW'(m_reads & 'h3F);
      w[7] = m_erase ? 1'b0 : ~m_final[7];
      w[6] = m_tgl;
      m_tgl = ~m_tgl;
    end else if (m_partial > 0) begin
      m_partial--;
      w = m_final ^ 16'h0300;
    end else begin
      w = m_final;
    end
    if (m_reads == m_corrupt) w = w ^ 16'h0001;
    return w;
  endfunction

  initial begin : responder
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        rd_ack  = 1'b1;
        rd_data = model_word();
      end else begin
        rd_ack = 1'b0;
      end
    end
  end

  // kind: 0 done, 1 mismatch, 2 timeout
  task automatic run_op(string req, bit op_er, bit op_tg, logic [AW-1:0] a,
                        logic [DW-1:0] fin, int mx, int b, int p, bit t0,
                        int corrupt, int kind, int exp_n, int exp_reads, bit inject);
    int n = 0;
    bit seen = 0;
    m_busy = b; m_partial = p; m_tgl = t0; m_final = fin; m_erase = op_er;
    m_reads = 0; m_corrupt = corrupt;
    @(negedge clk);
    start = 1; erase = op_er; tgl = op_tg; addr = a; expd = fin; maxp = CW'(mx);
    @(posedge clk);
    while (!seen && n < 2000) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 0;
        chk(busy && rd_req && rd_addr == a, {req, " R2 start"}, int'(rd_addr), int'(a));
      end
      if (inject && n == 3) begin
        start = 1; addr = a ^ 20'h0F0F0; erase = ~op_er;
      end
      if (inject && n == 4) begin
        start = 0;
        chk(rd_addr == a, "R3 addr kept", int'(rd_addr), int'(a));
      end
      if (done || err) begin
        seen = 1;
        chk(n == exp_n, {req, " R7 outcome cycle"}, n, exp_n);
        chk(done == (kind == 0) && err == (kind != 0), {req, " R8 outcome"},
            int'({done, err}), (kind == 0) ? 2 : 1);
        if (kind != 0) chk(err_to == (kind == 2), {req, " R9 err kind"}, int'(err_to), int'(kind == 2));
        chk(!busy && !(done && err), {req, " R10 busy/excl"}, int'(busy), 0);
        chk(m_reads == exp_reads, {req, " reads"}, m_reads, exp_reads);
      end
    end
    if (!seen) chk(0, {req, " watchdog no outcome"}, n, exp_n);
    @(negedge clk);
    chk(!done && !err && !busy, {req, " R10 pulse width"}, int'({done, err}), 0);
    repeat (3) @(negedge clk);
  endtask

  // done at n = 2h+2+2S ; first-confirm fail at 2h+S+1 ; timeout at 2M
  task automatic t_reset();
    chk(!rd_req && !busy && !done && !err, "R1 in reset", int'({rd_req, busy, done, err}), 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!rd_req && !busy && !done && !err, "R1 after reset", int'({rd_req, busy, done, err}), 0);
  endtask

  task automatic t_flag_prog();
    run_op("R4 flag prog b7=0", 0, 0, 20'h12345, 16'h1234, 20, 4, 0, 0, -1, 0, 2*5+2+2*S, 7, 0);
    run_op("R4 flag prog b7=1", 0, 0, 20'h00010, 16'hBEEF, 20, 2, 0, 0, -1, 0, 2*3+2+2*S, 5, 0);
  endtask

  task automatic t_flag_erase();
    run_op("R5 flag erase", 1, 0, 20'h40000, 16'hFFFF, 20, 3, 0, 0, -1, 0, 2*4+2+2*S, 6, 0);
  endtask

  task automatic t_toggle();
    run_op("R6 tgl prog late", 0, 1, 20'h00200, 16'h0040, 20, 3, 0, 0, -1, 0, 2*5+2+2*S, 7, 0);
    run_op("R6 tgl erase", 1, 1, 20'h00300, 16'hFFFF, 20, 4, 0, 0, -1, 0, 2*5+2+2*S, 7, 0);
    run_op("R6 tgl first read", 0, 1, 20'h00400, 16'h1111, 20, 0, 0, 0, -1, 0, 2*2+2+2*S, 4, 0);
  endtask

  task automatic t_confirm();
    run_op("R8 partial ok", 0, 0, 20'h00500, 16'h2222, 20, 2, 1, 0, -1, 0, 2*3+2+2*S, 5, 0);
    run_op("R8 first conf bad", 0, 0, 20'h00600, 16'h3333, 20, 2, 2, 0, -1, 1, 2*3+S+1, 4, 0);
    run_op("R8 erase not ones", 1, 0, 20'h00700, 16'hFFFE, 20, 1, 0, 0, -1, 1, 2*2+S+1, 3, 0);
    run_op("R8 second conf bad", 0, 0, 20'h00800, 16'h4444, 20, 2, 0, 0, 5, 1, 2*3+2+2*S, 5, 0);
  endtask

  task automatic t_timeout();
    run_op("R9 timeout", 0, 0, 20'h00900, 16'h5555, 5, 50, 0, 0, -1, 2, 10, 5, 0);
    run_op("R9 zero budget", 0, 1, 20'h00A00, 16'h5555, 0, 50, 0, 0, -1, 2, 2, 1, 0);
    run_op("R9 last poll hit", 0, 0, 20'h00B00, 16'h5555, 5, 4, 0, 0, -1, 0, 2*5+2+2*S, 7, 0);
  endtask

  task automatic t_busy_start();
    run_op("R3 start ignored", 0, 0, 20'h00C00, 16'h6666, 20, 3, 0, 0, -1, 0, 2*4+2+2*S, 6, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    checks++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin : main
    t_reset();
    t_flag_prog();
    t_flag_erase();
    t_toggle();
    t_confirm();
    t_timeout();
    t_busy_start();
    finish_run();
  end
endmodule